// File: doc/BRIEF.md
# LPC Peripheral Cycle Decoder

This block is the target side of a Low Pin Count bus for a peripheral controller. It runs on the 33 MHz bus clock. It watches the 4-bit multiplexed address/data lines and the active-low frame strobe, one nibble per clock. It completes single-byte I/O reads and writes whose 16-bit address falls inside a parameterised window. Toward the register file it raises a one-clock read or write strobe. Single-byte DMA cycles are also accepted. For these it raises a put or get strobe toward a channel-side port, carrying the channel number and the terminal-count flag.

Cycles of any other kind are ignored. So are I/O cycles outside the window and DMA cycles of any other size. The block drives nothing for them and waits for the next start. A low frame strobe overrides every state. The block releases the lines on the next clock and begins decoding again.

The states are IDLE, CTYPE, ADDR, DCHAN, DSIZE, HDATA, HTAR, SYNC, DDATA, DTAR_DRV and DTAR_REL. The transitions are as follows:
- IDLE waits.
- A start moves to CTYPE.
- CTYPE moves to ADDR for I/O, to DCHAN for DMA, and to IDLE for anything else.
- ADDR moves after four nibbles, to HDATA or HTAR when the address is in the window and to IDLE when it is not.
- DCHAN moves to DSIZE.
- DSIZE moves to HDATA or HTAR when the size is one byte, and to IDLE otherwise.
- HDATA moves to HTAR after two nibbles.
- HTAR moves to SYNC after two clocks.
- SYNC moves after its wait syncs, to DTAR_DRV when the data went to the device and to DDATA when the data goes to the host.
- DDATA moves to DTAR_DRV after two nibbles.
- DTAR_DRV moves to DTAR_REL.
- DTAR_REL moves to IDLE.
- From any state, a low frame strobe moves to CTYPE when the lines read 4'b0000 and to IDLE otherwise.

Top module: `lpc_cycle_target`

## Requirements
- R1: While rst_n is low, lad_oe is 0 and all strobes are 0, and the block restarts in IDLE; this holds even when reset arrives mid-cycle.
- R2: A cycle starts when frame_n is low and lad_in is 4'b0000 on the last clock frame_n is low. The next nibble selects the cycle kind: 4'b0000 I/O read, 4'b0010 I/O write, 4'b1000 DMA toward the device, 4'b1010 DMA toward the host.
- R3: Any other cycle-kind nibble is ignored: lad_oe stays 0, no strobe fires, and a 4'b0000 nibble seen while frame_n is high does not start a cycle.
- R4: An I/O address is four nibbles, most significant first. The cycle is claimed only when BASE <= address < BASE+SIZE; otherwise lad_oe stays 0 and no strobe fires.
- R5: Data bytes travel as two nibbles, least significant nibble first, in both directions.
- R6: During the two host turnaround clocks after the host's last nibble, lad_oe is 0.
- R7: A claimed cycle drives WAIT_SYNCS nibbles of 4'b0101, then one 4'b0000 ready nibble.
- R8: I/O write pulses reg_wr for one clock in the ready-sync clock, with reg_addr and reg_wdata valid. I/O read pulses reg_rd in the ready-sync clock, samples reg_rdata at that edge, and returns it in the next two clocks.
- R9: In a DMA cycle, the nibble after the kind carries the channel in bits 2:0 and terminal count in bit 3. The following size nibble must be 4'b0000, or the cycle is ignored. A to-device cycle pulses chn_put with chn_wdata in the ready clock. A to-host cycle pulses chn_get, samples chn_rdata, and returns it.
- R10: After its last sync or data nibble, the block drives 4'b1111 for one clock, then holds lad_oe at 0.
- R11: When frame_n is sampled low in any state, lad_oe is 0 from the next clock on, and decoding restarts under R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low interface reset, asynchronous |
| frame_n | input | 1 | Active-low cycle start / abort strobe |
| lad_in | input | 4 | Nibble sampled from the bus |
| lad_out | output | 4 | Nibble driven onto the bus |
| lad_oe | output | 1 | Bus drive enable |
| reg_addr | output | 16 | I/O address of the current cycle |
| reg_wdata | output | 8 | Write data toward the register file |
| reg_wr | output | 1 | One-clock register write strobe |
| reg_rd | output | 1 | One-clock register read strobe |
| reg_rdata | input | 8 | Read data, sampled on the reg_rd clock |
| chn_id | output | 3 | DMA channel number |
| chn_tc | output | 1 | DMA terminal-count flag |
| chn_wdata | output | 8 | DMA data toward the channel |
| chn_put | output | 1 | One-clock DMA to-device strobe |
| chn_get | output | 1 | One-clock DMA to-host strobe |
| chn_rdata | input | 8 | DMA data from the channel, sampled on the chn_get clock |

## Verification
A wrong state in this decoder shows on lad_oe and lad_out within the clock it goes wrong. Examples are a lost nibble count or a wrong claim decision. The bus is then driven during a host turnaround, a sync arrives one clock early or late, or data nibbles come out swapped. A lost abort shows as lad_oe still high one clock after frame_n was sampled low. A wrong claim decision shows as a strobe firing, or missing, in the ready-sync clock. The bench compares each bus clock of every cycle against the nibble the requirements predict for it.

// File: rtl/lpc_tgt_pkg.sv
package lpc_tgt_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CTYPE,
        ST_ADDR,
        ST_DCHAN,
        ST_DSIZE,
        ST_HDATA,
        ST_HTAR,
        ST_SYNC,
        ST_DDATA,
        ST_DTAR_DRV,
        ST_DTAR_REL
    } lpc_state_e;

    localparam logic [3:0] NIB_START      = 4'b0000;
    localparam logic [3:0] KIND_IO_RD     = 4'b0000;
    localparam logic [3:0] KIND_IO_WR     = 4'b0010;
    localparam logic [3:0] KIND_DMA_TODEV = 4'b1000;
    localparam logic [3:0] KIND_DMA_TOHST = 4'b1010;
    localparam logic [3:0] SYNC_READY     = 4'b0000;
    localparam logic [3:0] SYNC_SHORT     = 4'b0101;
    localparam logic [3:0] NIB_TURN       = 4'b1111;
    localparam logic [3:0] SIZE_ONE_BYTE  = 4'b0000;

endpackage

// File: rtl/lpc_win_match.sv
module lpc_win_match #(
    parameter int          ADDR_W = 16,
    parameter int unsigned BASE   = 32'h0000_0360,
    parameter int unsigned SIZE   = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);
    localparam logic [ADDR_W:0] LO = (ADDR_W+1)'(BASE);
    localparam logic [ADDR_W:0] HI = (ADDR_W+1)'(BASE + SIZE);

    logic [ADDR_W:0] wide;

    always_comb begin
        wide = {1'b0, addr};
        hit  = (wide >= LO) && (wide < HI);
    end
endmodule

// File: rtl/lpc_sync_pacer.sv
module lpc_sync_pacer #(
    parameter int WAITS = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic ready
);
    localparam int CW = (WAITS < 1) ? 1 : $clog2(WAITS + 1);

    logic [CW-1:0] cnt;

    assign ready = (cnt == CW'(WAITS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!active) begin
            cnt <= '0;
        end else if (!ready) begin
            cnt <= cnt + CW'(1);
        end
    end
endmodule

// File: rtl/lpc_nib_collect.sv
module lpc_nib_collect #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              addr_shift,
    input  logic              data_shift,
    input  logic              data_load,
    input  logic [3:0]        nib_in,
    input  logic [DATA_W-1:0] load_val,
    output logic [ADDR_W-1:0] addr,
    output logic [DATA_W-1:0] data
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
            data <= '0;
        end else begin
            if (addr_shift) begin
                addr <= {addr[ADDR_W-5:0], nib_in};
            end
            if (data_load) begin
                data <= load_val;
            end else if (data_shift) begin
                data <= {nib_in, data[DATA_W-1:4]};
            end
        end
    end
endmodule

// File: rtl/lpc_cycle_target.sv
module lpc_cycle_target
    import lpc_tgt_pkg::*;
#(
    parameter int unsigned WIN_BASE   = 32'h0000_0360,
    parameter int unsigned WIN_SIZE   = 16,
    parameter int          WAIT_SYNCS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n,
    input  logic [3:0]  lad_in,
    output logic [3:0]  lad_out,
    output logic        lad_oe,
    output logic [15:0] reg_addr,
    output logic [7:0]  reg_wdata,
    output logic        reg_wr,
    output logic        reg_rd,
    input  logic [7:0]  reg_rdata,
    output logic [2:0]  chn_id,
    output logic        chn_tc,
    output logic [7:0]  chn_wdata,
    output logic        chn_put,
    output logic        chn_get,
    input  logic [7:0]  chn_rdata
);
    localparam int ADDR_W    = 16;
    localparam int DATA_W    = 8;
    localparam int ADDR_NIBS = ADDR_W / 4;
    localparam int DATA_NIBS = DATA_W / 4;
    localparam int CNT_W     = $clog2(ADDR_NIBS);

    lpc_state_e        state, nxt;
    logic [CNT_W-1:0]  cnt, cnt_nxt;
    logic              is_dma, to_dev;
    logic [2:0]        chan_q;
    logic              tc_q;

    logic [ADDR_W-1:0] addr_q, addr_peek;
    logic [DATA_W-1:0] data_q;
    logic              win_hit;
    logic              sync_ready;
    logic              addr_shift, data_shift, data_load;

    assign addr_peek = {addr_q[ADDR_W-5:0], lad_in};

    lpc_win_match #(
        .ADDR_W (ADDR_W),
        .BASE   (WIN_BASE),
        .SIZE   (WIN_SIZE)
    ) u_win (
        .addr (addr_peek),
        .hit  (win_hit)
    );

    lpc_sync_pacer #(
        .WAITS (WAIT_SYNCS)
    ) u_pacer (
        .clk    (clk),
        .rst_n  (rst_n),
        .active (state == ST_SYNC),
        .ready  (sync_ready)
    );

    lpc_nib_collect #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_collect (
        .clk        (clk),
        .rst_n      (rst_n),
        .addr_shift (addr_shift),
        .data_shift (data_shift),
        .data_load  (data_load),
        .nib_in     (lad_in),
        .load_val   (is_dma ? chn_rdata : reg_rdata),
        .addr       (addr_q),
        .data       (data_q)
    );

    // State register together with the per-cycle attributes it latches.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            is_dma <= 1'b0;
            to_dev <= 1'b0;
            chan_q <= '0;
            tc_q   <= 1'b0;
        end else begin
            state <= nxt;
            cnt   <= cnt_nxt;
            if (state == ST_CTYPE) begin
                is_dma <= lad_in[3];
                to_dev <= lad_in[3] ? ~lad_in[1] : lad_in[1];
            end
            if (state == ST_DCHAN) begin
                chan_q <= lad_in[2:0];
                tc_q   <= lad_in[3];
            end
        end
    end

    // Next-state decision; a low frame strobe overrides every state.
    always_comb begin
        nxt     = state;
        cnt_nxt = cnt;
        unique case (state)
            ST_IDLE: begin
                nxt = ST_IDLE;
            end
            ST_CTYPE: begin
                cnt_nxt = '0;
                if (lad_in == KIND_IO_RD || lad_in == KIND_IO_WR) begin
                    nxt = ST_ADDR;
                end else if (lad_in == KIND_DMA_TODEV || lad_in == KIND_DMA_TOHST) begin
                    nxt = ST_DCHAN;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_ADDR: begin
                if (cnt == CNT_W'(ADDR_NIBS - 1)) begin
                    cnt_nxt = '0;
                    if (win_hit) begin
                        nxt = to_dev ? ST_HDATA : ST_HTAR;
                    end else begin
                        nxt = ST_IDLE;
                    end
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_DCHAN: begin
                nxt = ST_DSIZE;
            end
            ST_DSIZE: begin
                cnt_nxt = '0;
                if (lad_in == SIZE_ONE_BYTE) begin
                    nxt = to_dev ? ST_HDATA : ST_HTAR;
                end else begin
                    nxt = ST_IDLE;
                end
            end
            ST_HDATA: begin
                if (cnt == CNT_W'(DATA_NIBS - 1)) begin
                    cnt_nxt = '0;
                    nxt     = ST_HTAR;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_HTAR: begin
                if (cnt == CNT_W'(1)) begin
                    cnt_nxt = '0;
                    nxt     = ST_SYNC;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_SYNC: begin
                cnt_nxt = '0;
                if (sync_ready) begin
                    nxt = to_dev ? ST_DTAR_DRV : ST_DDATA;
                end
            end
            ST_DDATA: begin
                if (cnt == CNT_W'(DATA_NIBS - 1)) begin
                    cnt_nxt = '0;
                    nxt     = ST_DTAR_DRV;
                end else begin
                    cnt_nxt = cnt + CNT_W'(1);
                end
            end
            ST_DTAR_DRV: begin
                nxt = ST_DTAR_REL;
            end
            ST_DTAR_REL: begin
                nxt = ST_IDLE;
            end
            default: begin
                nxt     = ST_IDLE;
                cnt_nxt = '0;
            end
        endcase
        if (!frame_n) begin
            nxt     = (lad_in == NIB_START) ? ST_CTYPE : ST_IDLE;
            cnt_nxt = '0;
        end
    end

    // Outputs as a function of the present state.
    always_comb begin
        lad_oe     = 1'b0;
        lad_out    = NIB_TURN;
        reg_wr     = 1'b0;
        reg_rd     = 1'b0;
        chn_put    = 1'b0;
        chn_get    = 1'b0;
        addr_shift = (state == ST_ADDR);
        data_shift = (state == ST_HDATA);
        data_load  = 1'b0;
        unique case (state)
            ST_SYNC: begin
                lad_oe  = 1'b1;
                lad_out = sync_ready ? SYNC_READY : SYNC_SHORT;
                if (sync_ready) begin
                    reg_wr    = !is_dma &&  to_dev;
                    reg_rd    = !is_dma && !to_dev;
                    chn_put   =  is_dma &&  to_dev;
                    chn_get   =  is_dma && !to_dev;
                    data_load = !to_dev;
                end
            end
            ST_DDATA: begin
                lad_oe  = 1'b1;
                lad_out = (cnt == '0) ? data_q[3:0] : data_q[7:4];
            end
            ST_DTAR_DRV: begin
                lad_oe  = 1'b1;
                lad_out = NIB_TURN;
            end
            default: begin
                lad_oe = 1'b0;
            end
        endcase
    end

    assign reg_addr  = addr_q;
    assign reg_wdata = data_q;
    assign chn_wdata = data_q;
    assign chn_id    = chan_q;
    assign chn_tc    = tc_q;

endmodule

// File: rtl/lpc_cycle_target_chk.sv
module lpc_cycle_target_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frame_n,
    input logic [3:0] lad_out,
    input logic       lad_oe,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic       chn_put,
    input logic       chn_get
);
    // R11
    frame_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_n |=> !lad_oe);

    // R8
    one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr, reg_rd, chn_put, chn_get}));

    // R7
    strobe_on_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr || reg_rd || chn_put || chn_get) |-> (lad_oe && lad_out == 4'b0000));

    // R7
    first_drive_is_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lad_oe) |-> (lad_out == 4'b0101 || lad_out == 4'b0000));

    // R10
    write_turn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_wr || chn_put) && frame_n) |=> (lad_oe && lad_out == 4'b1111));

    // R8
    read_data_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((reg_rd || chn_get) && frame_n) |=> lad_oe);
endmodule

bind lpc_cycle_target lpc_cycle_target_chk u_chk (.*);

// File: tb/test_lpc_cycle_target.sv
module test_lpc_cycle_target;
    localparam int unsigned BASE = 32'h0000_0360;
    localparam int unsigned SIZE = 16;
    localparam int          W    = 2;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        frame_n;
    logic [3:0]  lad_in;
    logic [3:0]  lad_out;
    logic        lad_oe;
    logic [15:0] reg_addr;
    logic [7:0]  reg_wdata;
    logic        reg_wr, reg_rd;
    logic [7:0]  reg_rdata;
    logic [2:0]  chn_id;
    logic        chn_tc;
    logic [7:0]  chn_wdata;
    logic        chn_put, chn_get;
    logic [7:0]  chn_rdata;

    int tests = 0;
    int fails = 0;
    int n_wr = 0, n_rd = 0, n_put = 0, n_get = 0;

    always #2 clk = ~clk;

    assign reg_rdata = reg_addr[7:0] ^ 8'h5A;

    lpc_cycle_target #(
        .WIN_BASE   (BASE),
        .WIN_SIZE   (SIZE),
        .WAIT_SYNCS (W)
    ) i_lpc_cycle_target (
        .clk, .rst_n, .frame_n, .lad_in, .lad_out, .lad_oe,
        .reg_addr, .reg_wdata, .reg_wr, .reg_rd, .reg_rdata,
        .chn_id, .chn_tc, .chn_wdata, .chn_put, .chn_get, .chn_rdata
    );

    always @(posedge clk) begin
        if (rst_n) begin
            n_wr  += int'(reg_wr);
            n_rd  += int'(reg_rd);
            n_put += int'(chn_put);
            n_get += int'(chn_get);
        end
    end

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step(input logic f, input logic [3:0] d);
        @(negedge clk);
        frame_n = f;
        lad_in  = d;
    endtask

    task automatic host_tar();
        for (int i = 0; i < 2; i++) begin
            @(negedge clk);
            check("R6 host turnaround released", 16'(lad_oe), 16'd0);
            frame_n = 1'b1;
            lad_in  = 4'hF;
        end
    endtask

    task automatic sync_phase();
        for (int k = 0; k < W; k++) begin
            @(negedge clk);
            check("R7 wait sync", {11'd0, lad_oe, lad_out}, {11'd0, 1'b1, 4'b0101});
        end
        @(negedge clk);
        check("R7 ready sync", {11'd0, lad_oe, lad_out}, {11'd0, 1'b1, 4'b0000});
    endtask

    task automatic dev_tail(input logic send, input logic [7:0] val);
        if (send) begin
            @(negedge clk);
            check("R5 low nibble first", {11'd0, lad_oe, lad_out}, {11'd0, 1'b1, val[3:0]});
            @(negedge clk);
            check("R5 high nibble second", {11'd0, lad_oe, lad_out}, {11'd0, 1'b1, val[7:4]});
        end
        @(negedge clk);
        check("R10 drive 1111", {11'd0, lad_oe, lad_out}, {11'd0, 1'b1, 4'hF});
        @(negedge clk);
        check("R10 release", 16'(lad_oe), 16'd0);
    endtask

    task automatic silent(input string req, input int clocks);
        int seen = 0;
        for (int i = 0; i < clocks; i++) begin
            @(negedge clk);
            if (lad_oe) seen++;
        end
        check(req, 16'(seen), 16'd0);
    endtask

    task automatic io_cycle(input logic wr, input logic [15:0] a, input logic [7:0] wd,
                            input logic claim, input logic with_start);
        int w0 = n_wr;
        int r0 = n_rd;
        if (with_start) step(1'b0, 4'h0);
        step(1'b1, wr ? 4'b0010 : 4'b0000);
        for (int i = 3; i >= 0; i--) step(1'b1, a[i*4 +: 4]);
        if (wr && claim) begin
            step(1'b1, wd[3:0]);
            step(1'b1, wd[7:4]);
        end
        if (claim) begin
            host_tar();
            sync_phase();
            check("R4 address MSB first", reg_addr, a);
            if (wr) begin
                check("R8 reg_wr in ready clock", 16'(reg_wr), 16'd1);
                check("R5 write data assembled", 16'(reg_wdata), 16'(wd));
            end else begin
                check("R8 reg_rd in ready clock", 16'(reg_rd), 16'd1);
            end
            dev_tail(!wr, a[7:0] ^ 8'h5A);
        end else begin
            if (wr) begin
                step(1'b1, wd[3:0]);
                step(1'b1, wd[7:4]);
            end
            silent("R4 out-of-window silent", W + 6);
        end
        @(negedge clk);
        check("R8 write strobe count", 16'(n_wr - w0), 16'((wr && claim) ? 1 : 0));
        check("R8 read strobe count", 16'(n_rd - r0), 16'((!wr && claim) ? 1 : 0));
    endtask

    task automatic dma_cycle(input logic todev, input logic [2:0] ch, input logic tc,
                             input logic [3:0] size, input logic [7:0] d);
        int p0 = n_put;
        int g0 = n_get;
        logic claim = (size == 4'b0000);
        step(1'b0, 4'h0);
        step(1'b1, todev ? 4'b1000 : 4'b1010);
        step(1'b1, {tc, ch});
        step(1'b1, size);
        if (todev) begin
            step(1'b1, d[3:0]);
            step(1'b1, d[7:4]);
        end
        if (claim) begin
            host_tar();
            sync_phase();
            check("R9 channel id", 16'(chn_id), 16'(ch));
            check("R9 terminal count", 16'(chn_tc), 16'(tc));
            if (todev) begin
                check("R9 chn_put", 16'(chn_put), 16'd1);
                check("R9 chn_wdata", 16'(chn_wdata), 16'(d));
            end else begin
                check("R9 chn_get", 16'(chn_get), 16'd1);
            end
            dev_tail(!todev, chn_rdata);
        end else begin
            silent("R9 wrong size ignored", W + 6);
        end
        @(negedge clk);
        check("R9 put count", 16'(n_put - p0), 16'((todev && claim) ? 1 : 0));
        check("R9 get count", 16'(n_get - g0), 16'((!todev && claim) ? 1 : 0));
    endtask

    task automatic t_reset();
        check("R1 oe low in reset", 16'(lad_oe), 16'd0);
        check("R1 strobes low in reset", 16'({reg_wr, reg_rd, chn_put, chn_get}), 16'd0);
    endtask

    task automatic t_window();
        io_cycle(1'b0, 16'h0360, 8'h00, 1'b1, 1'b1);
        io_cycle(1'b1, 16'h036F, 8'hC3, 1'b1, 1'b1);
        io_cycle(1'b0, 16'h0370, 8'h00, 1'b0, 1'b1);
        io_cycle(1'b1, 16'h035F, 8'h81, 1'b0, 1'b1);
        io_cycle(1'b1, 16'h0364, 8'h1F, 1'b1, 1'b1);
    endtask

    task automatic t_long_frame();
        // R2: frame low for two clocks; only the last low nibble counts.
        step(1'b0, 4'hF);
        step(1'b0, 4'h0);
        io_cycle(1'b0, 16'h0366, 8'h00, 1'b1, 1'b0);
    endtask

    task automatic t_unsupported();
        int s0 = n_wr + n_rd + n_put + n_get;
        step(1'b0, 4'h0);
        step(1'b1, 4'b0100);
        for (int i = 0; i < 8; i++) step(1'b1, (i % 2 == 0) ? 4'h0 : 4'h3);
        silent("R3 unsupported kind silent", W + 6);
        check("R3 no strobe for unsupported kind", 16'(n_wr + n_rd + n_put + n_get - s0), 16'd0);
        io_cycle(1'b0, 16'h0361, 8'h00, 1'b1, 1'b1);
    endtask

    task automatic t_abort();
        int r0 = n_rd;
        int w0 = n_wr;
        step(1'b0, 4'h0);
        step(1'b1, 4'b0000);
        for (int i = 3; i >= 0; i--) step(1'b1, 4'(16'h0362 >> (i * 4)));
        host_tar();
        @(negedge clk);
        check("R11 driving wait sync before abort", 16'(lad_oe), 16'd1);
        frame_n = 1'b0;
        lad_in  = 4'hF;
        @(negedge clk);
        check("R11 released one clock after abort", 16'(lad_oe), 16'd0);
        frame_n = 1'b1;
        silent("R11 stays released after abort", W + 3);
        check("R11 no read strobe after abort", 16'(n_rd - r0), 16'd0);
        // Abort mid-address by a fresh start, then complete a write.
        step(1'b0, 4'h0);
        step(1'b1, 4'b0010);
        step(1'b1, 4'h0);
        step(1'b1, 4'h3);
        step(1'b0, 4'h0);
        io_cycle(1'b1, 16'h0368, 8'hA7, 1'b1, 1'b0);
        check("R11 exactly one write after restart", 16'(n_wr - w0), 16'd1);
    endtask

    task automatic t_dma();
        chn_rdata = 8'hE4;
        dma_cycle(1'b1, 3'd5, 1'b1, 4'b0000, 8'h96);
        dma_cycle(1'b0, 3'd2, 1'b0, 4'b0000, 8'h00);
        dma_cycle(1'b1, 3'd1, 1'b0, 4'b0001, 8'h55);
    endtask

    task automatic t_reset_mid();
        step(1'b0, 4'h0);
        step(1'b1, 4'b0000);
        for (int i = 3; i >= 0; i--) step(1'b1, 4'(16'h036A >> (i * 4)));
        host_tar();
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R1 reset mid-cycle releases", 16'(lad_oe), 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        silent("R1 idle after reset", 4);
        io_cycle(1'b0, 16'h036A, 8'h00, 1'b1, 1'b1);
    endtask

    initial begin
        rst_n     = 1'b0;
        frame_n   = 1'b1;
        lad_in    = 4'hF;
        chn_rdata = 8'h00;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_window();
        t_long_frame();
        t_unsupported();
        t_abort();
        t_dma();
        t_reset_mid();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #400000;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule